// File: doc/BRIEF.md
# Field-Configurable PLA Evaluator

This block models a programmable logic array whose two planes are both loaded at run time. Each input reaches the AND plane as a true copy and as a complemented copy. Each product term chooses, for every input, the true copy, the complement, or neither. Each output ORs a programmed subset of the product terms, and one term may feed several outputs. A per-output polarity bit can then invert that sum. Only the programmed terms reach an output; the array does not decode every minterm.

The programming table is loaded one word at a time through a write port. The load is built for a system that writes the table once after reset and may patch single rows later. A done flag rises once every table word has been written at least once. Before that, the registered outputs are held at zero. The input vector is sampled on each rising clock edge. The result of that sample appears on the output register after the same edge.

Top module: `pla_eval`

## Requirements
- R1: A 2-bit literal code selects how an input enters a term. 2'b01 passes the true input and 2'b10 passes the complement. 2'b11 ignores the input, contributing 1. 2'b00 connects both copies, so the term is forced to 0.
- R2: A product term is the AND of its literals for all inputs. A term whose codes are all 2'b11 evaluates to 1.
- R3: Output j is the OR of every term whose OR-plane bit j is set. A single term may feed more than one output. A term with no OR-plane bits set affects no output.
- R4: The polarity word holds one bit per output. When bit j is set, output j is the complement of its OR sum.
- R5: Word layout is as follows. Address t (0 to N_TERM-1) writes term t. Its bits [2i+1:2i] are the literal code of input i, and its bits [2*N_IN+j] are the OR-plane bit to output j. Address N_TERM writes the polarity word in bits [N_OUT-1:0]. Writes to higher addresses change nothing.
- R6: While cfg_we is low, cfg_addr and cfg_word have no effect on the table.
- R7: cfg_done rises on the edge that completes writes to every address 0 to N_TERM, in any order, and stays high until reset.
- R8: pla_out is all zero after any edge at which cfg_done was low before the edge. This includes the edge that writes the last missing word.
- R9: pla_out after a rising edge equals the function of pla_in sampled at that edge. A table write on the same edge does not change that result; it takes effect from the next edge.
- R10: Reset (rst_n low, asynchronous) clears the table, cfg_done and pla_out.
- R11: With 3 inputs (A = pla_in[2], B = pla_in[1], C = pla_in[0]), 4 terms and 2 outputs, a suitable table gives pla_out[0] = AB' + AC + A'BC' and pla_out[1] = (AC + BC)'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | $clog2(N_TERM+1) | Table word address (term rows, then polarity) |
| cfg_word | input | 2*N_IN+N_OUT | Table word data |
| cfg_done | output | 1 | Every table word has been written |
| pla_in | input | N_IN | Input vector |
| pla_out | output | N_OUT | Registered output vector |

## Verification
A table write and an evaluation can share a clock edge. In that case the evaluation must see the table as it stood before the write. The bench provokes this by changing a term row while a new input vector is applied, with the row chosen so that the old and new tables disagree for that vector. It expects the old-table answer after that edge and the new-table answer after the next. The edge that writes the last missing word is judged the same way: cfg_done goes high, yet pla_out stays zero for one more edge.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_BOTH = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_SKIP = 2'b11
  } lit_code_e;

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = 3,
  parameter int CW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [AW-1:0]            cfg_addr,
  input  logic [CW-1:0]            cfg_word,
  output logic [N_TERM*2*N_IN-1:0] and_tbl,
  output logic [N_TERM*N_OUT-1:0]  or_tbl,
  output logic [N_OUT-1:0]         pol,
  output logic [N_TERM:0]          wr_sel,
  output logic                     done
);
  localparam int AND_W = 2 * N_IN;

  logic [N_TERM:0] written_q;

  for (genvar k = 0; k <= N_TERM; k++) begin : g_sel
    assign wr_sel[k] = cfg_we && (cfg_addr == AW'(k));
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        and_tbl[t*AND_W +: AND_W] <= '0;
        or_tbl[t*N_OUT +: N_OUT]  <= '0;
      end else if (wr_sel[t]) begin
        and_tbl[t*AND_W +: AND_W] <= cfg_word[AND_W-1:0];
        or_tbl[t*N_OUT +: N_OUT]  <= cfg_word[AND_W +: N_OUT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol       <= '0;
      written_q <= '0;
    end else begin
      if (wr_sel[N_TERM]) pol <= cfg_word[N_OUT-1:0];
      written_q <= written_q | wr_sel;
    end
  end

  assign done = &written_q;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4
) (
  input  logic [N_IN-1:0]          in_vec,
  input  logic [N_TERM*2*N_IN-1:0] and_tbl,
  output logic [N_TERM-1:0]        terms
);
  import pla_pkg::*;

  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    return (x & code[0]) | (~x & code[1]);
  endfunction

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit[i] = lit_pass(and_tbl[(t*N_IN + i)*2 +: 2], in_vec[i]);
    end
    assign terms[t] = &lit;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2
) (
  input  logic [N_TERM-1:0]       terms,
  input  logic [N_TERM*N_OUT-1:0] or_tbl,
  input  logic [N_OUT-1:0]        pol,
  output logic [N_OUT-1:0]        sums
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] hit;
    for (genvar t = 0; t < N_TERM; t++) begin : g_hit
      assign hit[t] = terms[t] & or_tbl[t*N_OUT + j];
    end
    assign sums[j] = (|hit) ^ pol[j];
  end
endmodule

// File: rtl/pla_eval.sv
module pla_eval #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  localparam int AW    = $clog2(N_TERM + 1),
  localparam int CW    = 2 * N_IN + N_OUT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CW-1:0]     cfg_word,
  output logic              cfg_done,
  input  logic [N_IN-1:0]   pla_in,
  output logic [N_OUT-1:0]  pla_out
);
  logic [N_TERM*2*N_IN-1:0] and_tbl;
  logic [N_TERM*N_OUT-1:0]  or_tbl;
  logic [N_OUT-1:0]         pol;
  logic [N_TERM:0]          wr_sel;
  logic [N_TERM-1:0]        term_vec;
  logic [N_OUT-1:0]         sum_vec;

  pla_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_word(cfg_word), .and_tbl(and_tbl), .or_tbl(or_tbl), .pol(pol),
    .wr_sel(wr_sel), .done(cfg_done)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .in_vec(pla_in), .and_tbl(and_tbl), .terms(term_vec)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .terms(term_vec), .or_tbl(or_tbl), .pol(pol), .sums(sum_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pla_out <= '0;
    else if (cfg_done) pla_out <= sum_vec;
    else               pla_out <= '0;
  end
endmodule

// File: rtl/pla_eval_chk.sv
module pla_eval_chk #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  parameter int AW     = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we,
  input logic [AW-1:0]            cfg_addr,
  input logic                     cfg_done,
  input logic [N_IN-1:0]          pla_in,
  input logic [N_OUT-1:0]         pla_out,
  input logic [N_TERM*2*N_IN-1:0] and_tbl,
  input logic [N_TERM*N_OUT-1:0]  or_tbl,
  input logic [N_OUT-1:0]         pol
);
  logic idle_wr;
  assign idle_wr = !cfg_we || (cfg_addr > AW'(N_TERM));

  assert_tbl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(and_tbl) && $stable(or_tbl) && $stable(pol)));

  assert_high_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_wr |=> ($stable(and_tbl) && $stable(or_tbl) && $stable(pol)));

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(cfg_we));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  assert_zero_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |=> (pla_out == '0));

  assert_out_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && $past(cfg_done) && !cfg_we && !$past(cfg_we) && $stable(pla_in))
      |=> $stable(pla_out));
endmodule

bind pla_eval pla_eval_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_done(cfg_done), .pla_in(pla_in), .pla_out(pla_out),
  .and_tbl(and_tbl), .or_tbl(or_tbl), .pol(pol)
);

// File: tb/sim_pla_eval.sv
`timescale 1ns/1ps
module sim_pla_eval;
  localparam int NI = 3, NT = 4, NO = 2;
  localparam int AW = $clog2(NT + 1);
  localparam int CW = 2 * NI + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_word = '0;
  logic cfg_done;
  logic [NI-1:0] pla_in = '0;
  logic [NO-1:0] pla_out;

  int checks = 0;
  int fails  = 0;

  logic [2*NI-1:0] m_and [NT];
  logic [NO-1:0]   m_or  [NT];
  logic [NO-1:0]   m_pol;

  always #2.5 clk = ~clk;

  pla_eval #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_word(cfg_word), .cfg_done(cfg_done), .pla_in(pla_in), .pla_out(pla_out)
  );

  function automatic logic [NO-1:0] model(input logic [NI-1:0] v);
    logic [NO-1:0] r = '0;
    for (int t = 0; t < NT; t++) begin
      logic on = 1'b1;
      for (int i = 0; i < NI; i++) begin
        case (m_and[t][2*i +: 2])
          2'b00: on = 1'b0;
          2'b01: if (!v[i]) on = 1'b0;
          2'b10: if (v[i]) on = 1'b0;
          default: ;
        endcase
      end
      if (on) r = r | m_or[t];
    end
    return r ^ m_pol;
  endfunction

  task automatic check(input string req, input logic [NO-1:0] got, input logic [NO-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: pla_out=%b expected %b", req, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int t = 0; t < NT; t++) begin m_and[t] = '0; m_or[t] = '0; end
    m_pol = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cfg_we = 1'b0;
    model_clear();
    @(negedge clk); rst_n = 1'b1;
  endtask

  // one edge: optional write plus an input vector, sampled 1 ns after the edge
  task automatic step(input logic we, input int addr, input logic [CW-1:0] w, input logic [NI-1:0] v);
    @(negedge clk);
    cfg_we = we; cfg_addr = AW'(addr); cfg_word = w; pla_in = v;
    @(posedge clk); #1;
    if (we && addr < NT) begin m_and[addr] = w[2*NI-1:0]; m_or[addr] = w[2*NI +: NO]; end
    else if (we && addr == NT) m_pol = w[NO-1:0];
    cfg_we = 1'b0;
  endtask

  function automatic logic [CW-1:0] tw(input logic [NO-1:0] o, input logic [1:0] ca,
                                       input logic [1:0] cb, input logic [1:0] cc);
    return {o, ca, cb, cc};
  endfunction

  task automatic load_reference();
    step(1, 0, tw(2'b01, 2'b01, 2'b10, 2'b11), 3'd0); // AB' -> F1
    step(1, 1, tw(2'b11, 2'b01, 2'b11, 2'b01), 3'd0); // AC  -> F1,F2
    step(1, 2, tw(2'b10, 2'b11, 2'b01, 2'b01), 3'd0); // BC  -> F2
    step(1, 3, tw(2'b01, 2'b10, 2'b01, 2'b10), 3'd0); // A'BC' -> F1
    step(1, NT, CW'(2'b10), 3'd0);                     // F2 inverted
    step(0, 0, '0, 3'd0);
  endtask

  task automatic t_reset_R10();
    do_reset(); #1;
    check("R10 out after reset", pla_out, '0);
    check_bit("R10 done after reset", cfg_done, 1'b0);
  endtask

  task automatic t_ignored_R6_R5();
    do_reset();
    step(0, 0, tw(2'b11, 2'b11, 2'b11, 2'b11), 3'd5);
    step(1, 7, tw(2'b11, 2'b11, 2'b11, 2'b11), 3'd5);
    check_bit("R6 no done from disabled/high writes", cfg_done, 1'b0);
    check("R8 out zero before done", pla_out, '0);
    for (int a = 0; a <= NT; a++) step(1, a, '0, 3'd5);
    step(0, 0, '0, 3'd5);
    check("R6 R5 table unaffected by ignored writes", pla_out, '0);
  endtask

  task automatic t_done_edge_R7_R8();
    do_reset();
    step(1, NT, CW'(2'b11), 3'd2);
    step(1, 2, '0, 3'd2);
    step(1, 0, '0, 3'd2);
    step(1, 3, '0, 3'd2);
    check_bit("R7 done low with one row missing", cfg_done, 1'b0);
    step(1, 1, '0, 3'd2);
    check_bit("R7 done after last word", cfg_done, 1'b1);
    check("R8 out zero on completing edge", pla_out, '0);
    step(0, 0, '0, 3'd2);
    check("R4 polarity on empty sums", pla_out, 2'b11);
  endtask

  task automatic t_reference_R11();
    logic a, b, c;
    do_reset();
    load_reference();
    for (int v = 0; v < 8; v++) begin
      step(0, 0, '0, 3'(v));
      a = v[2]; b = v[1]; c = v[0];
      check("R11 R3 R4 reference F1/F2", pla_out,
            {~((a & c) | (b & c)), (a & ~b) | (a & c) | (~a & b & ~c)});
      check("R9 model agreement", pla_out, model(3'(v)));
    end
  endtask

  task automatic t_literals_R1_R2();
    do_reset();
    load_reference();
    step(1, 3, tw(2'b10, 2'b11, 2'b11, 2'b11), 3'd7); // all-skip term feeds out1
    step(0, 0, '0, 3'd7);
    check("R2 all-skip term is one", pla_out, model(3'd7));
    step(1, 3, tw(2'b01, 2'b00, 2'b11, 2'b11), 3'd3);
    step(0, 0, '0, 3'd3);
    check("R1 code 00 kills term", pla_out, model(3'd3));
    step(0, 0, '0, 3'd4);
    check("R1 code 00 kills term alt", pla_out, model(3'd4));
    step(1, 1, tw(2'b00, 2'b01, 2'b11, 2'b01), 3'd5); // AC disconnected
    step(0, 0, '0, 3'd5);
    check("R3 term with no OR bits", pla_out, model(3'd5));
  endtask

  task automatic t_collision_R9();
    logic [NO-1:0] old_exp;
    do_reset();
    load_reference();
    old_exp = model(3'd6);
    step(1, 0, tw(2'b10, 2'b01, 2'b01, 2'b11), 3'd6); // row 0 now AB -> F2
    check("R9 same-edge write uses old table", pla_out, old_exp);
    step(0, 0, '0, 3'd6);
    check("R9 new table from next edge", pla_out, model(3'd6));
    check("R9 new table differs", pla_out, 2'b00);
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    t_reset_R10();
    t_ignored_R6_R5();
    t_done_edge_R7_R8();
    t_reference_R11();
    t_literals_R1_R2();
    t_collision_R9();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule